// File: doc/BRIEF.md
# Two-Channel One-Line Sample Delay

This block holds two streams of 8-bit colour-difference samples, one for R-Y and one for B-Y, for exactly one video line. The block runs from a master clock. A phase counter divides that clock by six to make the sample instants. At each sample instant the block stores the current input sample of each channel. In the same cycle it presents the sample held at the same position of the line before. Both channels share one position pointer and one phase counter, but their contents are independent.

A one-cycle line-start pulse marks the beginning of active video. The pulse resets the divide-by-six phase and the position pointer, so sample k of every line lands in the same storage cell. After 166 samples the block stops sampling until the next line-start. The inactive part of the line is therefore never stored. A strobe marks each new delayed sample. A level flag reports that every storage cell has been written at least once since reset.

Top module: `line_delay_2ch`

## Requirements
- R1: While a line is being stored, `dly_stb` pulses for one cycle once every 6 clock cycles. Each pulse is a new pair of delayed samples.
- R2: A line-start pulse seen at one clock edge makes the inputs present at the next edge sample 0 of the line. `dly_stb` is high in the cycle after that next edge, whatever the earlier phase was.
- R3: After the 166th sample of a line, no further `dly_stb` pulse occurs until the next line-start.
- R4: At the pulse for sample k, `ry_dly` equals the R-Y input stored at sample k of the previous stored line.
- R5: The B-Y channel follows R4 on its own 8-bit data, with no mixing between the channels.
- R6: If a line-start falls in a cycle in which a sample would be taken, the line-start wins. No sample is stored, `dly_stb` stays low in the next cycle, and the cell for that position keeps its older content.
- R7: `dly_valid` is low from reset until the cell for position 165 has been written. After that it stays high until the next reset.
- R8: While `rst_n` is low at a clock edge (synchronous, active low), the next cycle shows `dly_stb`=0, `dly_valid`=0 and both delayed outputs at 0. After reset, no strobe occurs before a line-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start | input | 1 | One-cycle pulse at start of active video |
| ry_in | input | 8 | R-Y input sample |
| by_in | input | 8 | B-Y input sample |
| ry_dly | output | 8 | R-Y sample from one line earlier |
| by_dly | output | 8 | B-Y sample from one line earlier |
| dly_stb | output | 1 | One-cycle pulse: new delayed pair presented |
| dly_valid | output | 1 | All storage cells written since reset |

## Verification
The line-start realignment and the sample instant can fall in the same cycle. The bench provokes this by raising line-start exactly in the cycle where the sixth phase would take sample 40 of a partly stored line. It then requires a silent cycle after that edge and the first new sample one edge later. On the following line it requires position 40 to return the value from two lines back rather than the skipped input. A second realignment lands two cycles off phase, to show that the restart does not depend on where the old phase stood.

// File: rtl/ldl_pkg.sv
// Shared constants for the two-channel line delay.
// Assumes: one master clock domain; colour channels indexed by ldl_ch_e.
package ldl_pkg;
    localparam int LDL_SMP_W = 8;    // bits per sample
    localparam int LDL_DEPTH = 166;  // samples stored per line
    localparam int LDL_DIV   = 6;    // master clocks per sample
    localparam int LDL_NCH   = 2;    // colour channels

    typedef enum logic {
        CH_RY = 1'b0,
        CH_BY = 1'b1
    } ldl_ch_e;
endpackage

// File: rtl/ldl_phase.sv
// Divides the master clock by DIV to make the sample tick.
// Assumes: realign is a one-cycle pulse; it forces phase 0 and
// suppresses any tick in its own cycle (realignment has priority).
module ldl_phase #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic realign,
    input  logic enable,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST_PH = CW'(DIV - 1);

    logic [CW-1:0] phase;

    // Phase counter: wraps at DIV-1, restarts on reset or realign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (realign || phase == LAST_PH) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Tick on phase 0 while storing, never together with realign.
    assign tick = enable && !realign && (phase == '0);
endmodule

// File: rtl/ldl_seq.sv
// Sequences one line of storage: pointer, active window, fill flag
// and output strobe.
// Assumes: tick already excludes the line-start cycle.
module ldl_seq #(
    parameter int DEPTH = 166,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          tick,
    output logic [AW-1:0] ptr,
    output logic          active,
    output logic          filled,
    output logic          stb
);
    localparam logic [AW-1:0] LAST_POS = AW'(DEPTH - 1);

    // Pointer and active window: restart on line start, stop after last cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            active <= 1'b0;
        end else if (line_start) begin
            ptr    <= '0;
            active <= 1'b1;
        end else if (tick) begin
            if (ptr == LAST_POS) begin
                ptr    <= '0;
                active <= 1'b0;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // Fill flag: set once the last cell has been written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filled <= 1'b0;
        end else if (tick && ptr == LAST_POS) begin
            filled <= 1'b1;
        end
    end

    // Output strobe: one cycle after each sample write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb <= 1'b0;
        end else begin
            stb <= tick;
        end
    end
endmodule

// File: rtl/ldl_store.sv
// One channel of line storage. On each write, the old cell content
// is moved to the output register in the same edge as the new sample
// is written (read before overwrite).
// Assumes: addr < DEPTH; storage itself is not reset.
module ldl_store #(
    parameter int W     = 8,
    parameter int DEPTH = 166,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);
    logic [W-1:0] cells [DEPTH];

    // Cell write on each sample tick.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= din;
        end
    end

    // Output register: captures the old content being replaced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (we) begin
            dout <= cells[addr];
        end
    end
endmodule

// File: rtl/line_delay_2ch.sv
// Two-channel one-line sample delay. Divides the master clock, aligns
// the phase and pointer to each line start, and stores DEPTH samples
// per line for each channel.
// Assumes: line_start is a single-cycle pulse; lines are at least
// DEPTH*DIV+1 clocks apart for complete lines.
module line_delay_2ch
    import ldl_pkg::*;
#(
    parameter int SMP_W = LDL_SMP_W,
    parameter int DEPTH = LDL_DEPTH,
    parameter int DIV   = LDL_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic [SMP_W-1:0] ry_in,
    input  logic [SMP_W-1:0] by_in,
    output logic [SMP_W-1:0] ry_dly,
    output logic [SMP_W-1:0] by_dly,
    output logic             dly_stb,
    output logic             dly_valid
);
    localparam int AW = $clog2(DEPTH);

    logic          tick;
    logic          active;
    logic [AW-1:0] ptr;
    logic [SMP_W-1:0] ch_in  [LDL_NCH];
    logic [SMP_W-1:0] ch_out [LDL_NCH];

    ldl_phase #(.DIV(DIV)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .realign (line_start),
        .enable  (active),
        .tick    (tick)
    );

    ldl_seq #(.DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .tick       (tick),
        .ptr        (ptr),
        .active     (active),
        .filled     (dly_valid),
        .stb        (dly_stb)
    );

    assign ch_in[CH_RY] = ry_in;
    assign ch_in[CH_BY] = by_in;

    for (genvar ch = 0; ch < LDL_NCH; ch++) begin : g_ch
        ldl_store #(.W(SMP_W), .DEPTH(DEPTH)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (tick),
            .addr  (ptr),
            .din   (ch_in[ch]),
            .dout  (ch_out[ch])
        );
    end

    assign ry_dly = ch_out[CH_RY];
    assign by_dly = ch_out[CH_BY];
endmodule

// File: rtl/ldl_chk.sv
// Port-level checker for line_delay_2ch, bound to every instance.
module ldl_chk #(
    parameter int DEPTH = 166,
    parameter int DIV   = 6
) (
    input logic clk,
    input logic rst_n,
    input logic line_start,
    input logic dly_stb,
    input logic dly_valid
);
    localparam int GW = $clog2(DIV + 2) + 1;
    localparam int NW = $clog2(DEPTH + 2) + 1;
    localparam logic [GW-1:0] GMAX = '1;
    localparam logic [NW-1:0] NMAX = '1;

    logic [GW-1:0] gap;
    logic          armed;
    logic [NW-1:0] nline;

    // Cycles since the previous strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || dly_stb) gap <= '0;
        else if (gap != GMAX)  gap <= gap + 1'b1;
    end

    // Armed after a strobe until the next line start.
    always_ff @(posedge clk) begin
        if (!rst_n || line_start) armed <= 1'b0;
        else if (dly_stb)         armed <= 1'b1;
    end

    // Strobes seen since the last line start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || line_start)        nline <= '0;
        else if (dly_stb && nline != NMAX) nline <= nline + 1'b1;
    end

    // R1
    stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_stb && armed) |-> (gap == GW'(DIV - 1)));

    // R2
    realign_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start ##1 !line_start) |=> dly_stb);

    // R3
    line_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nline <= NW'(DEPTH));

    // R6
    collide_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !dly_stb);

    // R7
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_valid |=> dly_valid);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!dly_valid && !dly_stb));
endmodule

bind line_delay_2ch ldl_chk #(.DEPTH(DEPTH), .DIV(DIV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .dly_stb    (dly_stb),
    .dly_valid  (dly_valid)
);

// File: tb/tb_line_delay_2ch.sv
module tb_line_delay_2ch;
    localparam int DEPTH = 166;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_start;
    logic [7:0] ry_in, by_in;
    logic [7:0] ry_dly, by_dly;
    logic       dly_stb, dly_valid;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    logic [7:0] m_ry [DEPTH];
    logic [7:0] m_by [DEPTH];
    bit         known [DEPTH];
    bit         filled_m = 0;
    logic [7:0] cap_ry [DEPTH];
    logic [7:0] cap_by [DEPTH];

    always #10 clk = ~clk;

    line_delay_2ch dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .ry_in(ry_in), .by_in(by_in), .ry_dly(ry_dly), .by_dly(by_dly),
        .dly_stb(dly_stb), .dly_valid(dly_valid)
    );

    function automatic logic [7:0] f_ry(int seed, int k);
        return 8'(seed * 37 + k * 13 + 5);
    endfunction

    function automatic logic [7:0] f_by(int seed, int k);
        return 8'((seed * 91) ^ (k * 7 + 200));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Count strobes over n cycles; must be zero.
    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            if (dly_stb) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    // Pulse line_start at the current negedge; strobe must stay low next cycle.
    task automatic start_line(input string req);
        line_start = 1'b1;
        @(posedge clk); @(negedge clk);
        line_start = 1'b0;
        chk(dly_stb == 1'b0, req, dly_stb, 0);
    endtask

    // Feed n samples from position 0; called in the cycle before sample 0.
    task automatic take_samples(input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            ry_in = f_ry(seed, k);
            by_in = f_by(seed, k);
            @(posedge clk); @(negedge clk);
            chk(dly_stb == 1'b1, (k == 0) ? "R2" : "R1", dly_stb, 1);
            cap_ry[k] = ry_dly;
            cap_by[k] = by_dly;
            if (k == DEPTH - 1) filled_m = 1;
            chk(dly_valid == filled_m, "R7", dly_valid, int'(filled_m));
            if (known[k]) begin
                chk(ry_dly == m_ry[k], "R4", ry_dly, m_ry[k]);
                chk(by_dly == m_by[k], "R5", by_dly, m_by[k]);
            end
            m_ry[k] = f_ry(seed, k);
            m_by[k] = f_by(seed, k);
            known[k] = 1;
            if (k < n - 1) begin
                repeat (5) @(posedge clk);
                @(negedge clk);
                chk(dly_stb == 1'b0, "R1", dly_stb, 0);
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; line_start = 1'b0; ry_in = '0; by_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dly_stb == 0 && dly_valid == 0, "R8", {dly_stb, dly_valid}, 0);
        chk(ry_dly == 0 && by_dly == 0, "R8", {ry_dly, by_dly}, 0);
        rst_n = 1'b1;
        quiet(20, "R8");
    endtask

    task automatic t_full_lines;
        start_line("R2");
        take_samples(DEPTH, 1);
        quiet(100, "R3");
        start_line("R2");
        take_samples(DEPTH, 2);
        quiet(30, "R3");
    endtask

    task automatic t_collide;
        start_line("R2");
        take_samples(40, 3);
        repeat (5) @(posedge clk);
        @(negedge clk);
        start_line("R6");
        take_samples(DEPTH, 4);
        chk(cap_ry[40] == f_ry(2, 40), "R6", cap_ry[40], f_ry(2, 40));
        chk(cap_by[40] == f_by(2, 40), "R6", cap_by[40], f_by(2, 40));
        chk(cap_ry[39] == f_ry(3, 39), "R6", cap_ry[39], f_ry(3, 39));
    endtask

    task automatic t_offphase;
        start_line("R2");
        take_samples(10, 5);
        repeat (2) @(posedge clk);
        @(negedge clk);
        start_line("R2");
        take_samples(DEPTH, 6);
        quiet(20, "R3");
    endtask

    task automatic t_reset_midline;
        start_line("R2");
        take_samples(20, 7);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(dly_valid == 0, "R7", dly_valid, 0);
        chk(dly_stb == 0 && ry_dly == 0 && by_dly == 0, "R8",
            {dly_stb, ry_dly, by_dly}, 0);
        rst_n = 1'b1;
        filled_m = 0;
        quiet(20, "R8");
        start_line("R2");
        take_samples(DEPTH, 8);
    endtask

    initial begin
        t_reset();
        t_full_lines();
        t_collide();
        t_offphase();
        t_reset_midline();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule